// File: doc/BRIEF.md
# Flag Offset Programming Port

This block holds the two threshold offsets that a FIFO's flag logic compares against: the almost-empty offset and the almost-full offset. While master reset is held, a strap input picks two things together: the default value of both offsets, and the single method allowed to change them later. That method is either a bit-serial shift from a one-bit input, or a parallel write from a data bus.

After reset, every access happens only while the active-low load strobe is held low. With load low, the serial enable shifts one bit per clock edge in serial mode, and the parallel write strobe stores a word in parallel mode. The parallel read strobe copies an offset to the readback register in either mode. Parallel accesses step through the two offsets in turn: almost-empty first, then almost-full. Both offsets go straight to the flag comparators, which live outside this block.

The control is a four-state machine. Each state pairs the loading method with the offset that the next parallel access will address:

- `ST_PAR_AE`: parallel mode, the next parallel access addresses the almost-empty offset.
- `ST_PAR_AF`: parallel mode, the next parallel access addresses the almost-full offset.
- `ST_SER_AE`: serial mode, the next readback addresses the almost-empty offset.
- `ST_SER_AF`: serial mode, the next readback addresses the almost-full offset.

The transitions are:

- Reset enters `ST_SER_AE` if the strap is high and `ST_PAR_AE` if it is low.
- An access moves `_AE` to `_AF` and `_AF` to `_AE` within the same mode. An access is a read, or, in parallel mode only, a write.
- Any other cycle keeps the current state.

Top module: `flag_offset_port`

## Requirements
- R1: A clock edge with `rst_n` low and `strap_serial` low sets both offsets to 0x07F and selects parallel mode.
- R2: A clock edge with `rst_n` low and `strap_serial` high sets both offsets to 0x3FF and selects serial mode.
- R3: In serial mode, each clock edge with `load_n` and `ser_en_n` both low shifts `ser_din` into the top bit of the 20-bit chain formed by {almost-full, almost-empty}. After 20 such edges, the first 10 bits sent sit in the almost-empty offset and the last 10 sit in the almost-full offset, each least significant bit first.
- R4: An edge with `ser_en_n` high and no parallel write leaves both offsets unchanged.
- R5: In parallel mode, an edge with `load_n` and `par_wr_n` both low stores `wdata` into the currently selected offset. The selection alternates almost-empty, almost-full, almost-empty, and so on.
- R6: In serial mode, `par_wr_n` has no effect: neither the offsets nor the selection change.
- R7: In parallel mode, `ser_en_n` and `ser_din` have no effect on the offsets.
- R8: In either mode, an edge with `load_n` and `par_rd_n` both low loads `rdata` with the selected offset's value from before that edge, and advances the selection. When a read and a write happen on the same edge, the selection advances only once.
- R9: While `load_n` is high, the offsets, the selection and `rdata` keep their values.
- R10: Reset returns the selection to the almost-empty offset and clears `rdata` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (the FIFO write clock) |
| rst_n | input | 1 | Master reset, active low, sampled on the clock |
| strap_serial | input | 1 | Strap sampled during reset: 1 selects serial mode with 0x3FF defaults, 0 selects parallel mode with 0x07F defaults |
| load_n | input | 1 | Active-low strobe that enables offset accesses |
| ser_en_n | input | 1 | Active-low serial shift enable |
| ser_din | input | 1 | Serial data bit |
| par_wr_n | input | 1 | Active-low parallel write strobe |
| par_rd_n | input | 1 | Active-low parallel read strobe |
| wdata | input | 10 | Parallel write data |
| rdata | output | 10 | Readback register |
| ae_offset | output | 10 | Almost-empty offset, sent to the flag logic |
| af_offset | output | 10 | Almost-full offset, sent to the flag logic |

## Verification
Every result of this block is registered once. A shift, a parallel write, a readback or a reset default therefore shows on `ae_offset`, `af_offset` or `rdata` right after the rising edge that sampled the stimulus. The bench drives each stimulus on the falling edge and compares 1 ns after the next rising edge. Its model applies the same one-edge rule, so each comparison covers exactly one sampled stimulus. A blocked write or an idle edge is checked at the same point: the offsets and `rdata` must still equal the model's unchanged values.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;
    typedef enum logic [1:0] {
        ST_PAR_AE = 2'b00,
        ST_PAR_AF = 2'b01,
        ST_SER_AE = 2'b10,
        ST_SER_AF = 2'b11
    } ofs_state_t;
endpackage

// File: rtl/ofs_mode_fsm.sv
module ofs_mode_fsm
    import ofs_prog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strap_serial,
    input  logic load_n,
    input  logic ser_en_n,
    input  logic par_wr_n,
    input  logic par_rd_n,
    output logic ser_mode,
    output logic sel_af,
    output logic wr_go,
    output logic shift_go,
    output logic rd_go
);
    ofs_state_t st, st_nx;
    logic       access;

    // state register; the strap is only looked at while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) st <= strap_serial ? ST_SER_AE : ST_PAR_AE;
        else        st <= st_nx;
    end

    // decoded controls
    always_comb begin
        ser_mode = (st == ST_SER_AE) || (st == ST_SER_AF);
        sel_af   = (st == ST_PAR_AF) || (st == ST_SER_AF);
        rd_go    = !load_n && !par_rd_n;
        wr_go    = !load_n && !par_wr_n && !ser_mode;
        shift_go = !load_n && !ser_en_n && ser_mode;
        access   = rd_go || wr_go;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_PAR_AE: if (access) st_nx = ST_PAR_AF;
            ST_PAR_AF: if (access) st_nx = ST_PAR_AE;
            ST_SER_AE: if (access) st_nx = ST_SER_AF;
            ST_SER_AF: if (access) st_nx = ST_SER_AE;
            default:   st_nx = ST_PAR_AE;
        endcase
    end
endmodule

// File: rtl/ofs_store.sv
module ofs_store #(
    parameter int OFS_W   = 10,
    parameter int DEF_PAR = 'h07F,
    parameter int DEF_SER = 'h3FF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_serial,
    input  logic             wr_go,
    input  logic             shift_go,
    input  logic             sel_af,
    input  logic             ser_din,
    input  logic [OFS_W-1:0] wdata,
    output logic [OFS_W-1:0] ae_q,
    output logic [OFS_W-1:0] af_q
);
    localparam int CHAIN_W = 2 * OFS_W;
    localparam logic [OFS_W-1:0] PAR_INIT = OFS_W'(DEF_PAR);
    localparam logic [OFS_W-1:0] SER_INIT = OFS_W'(DEF_SER);

    logic [CHAIN_W-1:0] chain_nx;

    // new bit enters at the top of the almost-full half; oldest bit leaves the bottom
    assign chain_nx = {ser_din, af_q, ae_q[OFS_W-1:1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ae_q <= strap_serial ? SER_INIT : PAR_INIT;
            af_q <= strap_serial ? SER_INIT : PAR_INIT;
        end else if (shift_go) begin
            {af_q, ae_q} <= chain_nx;
        end else if (wr_go) begin
            if (sel_af) af_q <= wdata;
            else        ae_q <= wdata;
        end
    end
endmodule

// File: rtl/ofs_readback.sv
module ofs_readback #(
    parameter int OFS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_go,
    input  logic             sel_af,
    input  logic [OFS_W-1:0] ae_q,
    input  logic [OFS_W-1:0] af_q,
    output logic [OFS_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_go) rdata <= sel_af ? af_q : ae_q;
    end
endmodule

// File: rtl/flag_offset_port.sv
module flag_offset_port #(
    parameter int OFS_W   = 10,
    parameter int DEF_PAR = 'h07F,
    parameter int DEF_SER = 'h3FF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_serial,
    input  logic             load_n,
    input  logic             ser_en_n,
    input  logic             ser_din,
    input  logic             par_wr_n,
    input  logic             par_rd_n,
    input  logic [OFS_W-1:0] wdata,
    output logic [OFS_W-1:0] rdata,
    output logic [OFS_W-1:0] ae_offset,
    output logic [OFS_W-1:0] af_offset
);
    logic ser_mode, sel_af, wr_go, shift_go, rd_go;

    ofs_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .strap_serial(strap_serial),
        .load_n(load_n), .ser_en_n(ser_en_n), .par_wr_n(par_wr_n),
        .par_rd_n(par_rd_n), .ser_mode(ser_mode), .sel_af(sel_af),
        .wr_go(wr_go), .shift_go(shift_go), .rd_go(rd_go)
    );

    ofs_store #(.OFS_W(OFS_W), .DEF_PAR(DEF_PAR), .DEF_SER(DEF_SER)) u_store (
        .clk(clk), .rst_n(rst_n), .strap_serial(strap_serial),
        .wr_go(wr_go), .shift_go(shift_go), .sel_af(sel_af),
        .ser_din(ser_din), .wdata(wdata), .ae_q(ae_offset), .af_q(af_offset)
    );

    ofs_readback #(.OFS_W(OFS_W)) u_rb (
        .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .sel_af(sel_af),
        .ae_q(ae_offset), .af_q(af_offset), .rdata(rdata)
    );
endmodule

// File: rtl/flag_offset_port_chk.sv
module flag_offset_port_chk #(
    parameter int OFS_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_n,
    input logic             ser_en_n,
    input logic             ser_din,
    input logic             par_wr_n,
    input logic             par_rd_n,
    input logic             ser_mode,
    input logic [OFS_W-1:0] rdata,
    input logic [OFS_W-1:0] ae_offset,
    input logic [OFS_W-1:0] af_offset
);
    // R9: with load high nothing moves
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> ($stable(ae_offset) && $stable(af_offset) && $stable(rdata)));

    // R4: serial enable high and no parallel write keeps both offsets
    assert_serial_off_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && ser_en_n && par_wr_n) |=> ($stable(ae_offset) && $stable(af_offset)));

    // R6: parallel write has no effect in serial mode
    assert_par_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode && !load_n && ser_en_n) |=> ($stable(ae_offset) && $stable(af_offset)));

    // R3: the newest serial bit lands at the top of the almost-full offset
    assert_shift_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode && !load_n && !ser_en_n) |=> (af_offset[OFS_W-1] == $past(ser_din)));

    // R7: parallel mode ignores the serial lines when no parallel write occurs
    assert_serial_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_mode && !load_n && !ser_en_n && par_wr_n) |=> ($stable(ae_offset) && $stable(af_offset)));

    // R8: readback returns one of the two offsets as they were before the edge
    assert_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !par_rd_n) |=> ((rdata == $past(ae_offset)) || (rdata == $past(af_offset))));
endmodule

bind flag_offset_port flag_offset_port_chk #(.OFS_W(OFS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .ser_en_n(ser_en_n),
    .ser_din(ser_din), .par_wr_n(par_wr_n), .par_rd_n(par_rd_n),
    .ser_mode(ser_mode), .rdata(rdata), .ae_offset(ae_offset), .af_offset(af_offset)
);

// File: tb/flag_offset_port_test.sv
`timescale 1ns/1ps
module flag_offset_port_test;
    localparam int W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0, strap_serial = 1'b0;
    logic load_n = 1'b1, ser_en_n = 1'b1, ser_din = 1'b0;
    logic par_wr_n = 1'b1, par_rd_n = 1'b1;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata, ae_offset, af_offset;

    int n_cmp = 0, n_bad = 0;

    // model state
    logic [W-1:0] m_ae, m_af, m_rd;
    logic m_ser, m_sel;

    always #2.5 clk = ~clk;

    flag_offset_port uut (
        .clk(clk), .rst_n(rst_n), .strap_serial(strap_serial), .load_n(load_n),
        .ser_en_n(ser_en_n), .ser_din(ser_din), .par_wr_n(par_wr_n),
        .par_rd_n(par_rd_n), .wdata(wdata), .rdata(rdata),
        .ae_offset(ae_offset), .af_offset(af_offset)
    );

    function automatic logic [W-1:0] def_val(input logic s);
        return s ? W'('h3FF) : W'('h07F);
    endfunction

    task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        cmp({tag, " ae"}, ae_offset, m_ae);
        cmp({tag, " af"}, af_offset, m_af);
        cmp({tag, " rdata"}, rdata, m_rd);
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst_n = 1'b0; strap_serial = s;
        load_n = 1'b1; ser_en_n = 1'b1; par_wr_n = 1'b1; par_rd_n = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; strap_serial = ~s;
        m_ae = def_val(s); m_af = def_val(s); m_rd = '0; m_ser = s; m_sel = 1'b0;
    endtask

    // one cycle of stimulus; model advanced from the requirements, compared after the edge
    task automatic step(input string tag, input logic ld, input logic sen, input logic din,
                        input logic wr, input logic rd, input logic [W-1:0] wd);
        logic acc;
        logic [2*W:0] ch;
        @(negedge clk);
        load_n = ld; ser_en_n = sen; ser_din = din; par_wr_n = wr; par_rd_n = rd; wdata = wd;
        @(posedge clk);
        acc = 1'b0;
        if (!ld) begin
            if (!rd) begin
                m_rd = m_sel ? m_af : m_ae;
                acc = 1'b1;
            end
            if (m_ser && !sen) begin
                ch = {din, m_af, m_ae};
                {m_af, m_ae} = ch[2*W:1];
            end else if (!m_ser && !wr) begin
                if (m_sel) m_af = wd; else m_ae = wd;
                acc = 1'b1;
            end
        end
        if (acc) m_sel = ~m_sel;
        #1;
        check_all(tag);
    endtask

    initial begin
        #900000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [2*W-1:0] pat;
        void'($urandom(32'd4242));

        // R1 / R10: parallel strap defaults
        do_reset(1'b0);
        #1; check_all("R1_R10 reset");
        step("R10 first read is ae", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0);
        step("R8 second read is af", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0);
        // R5: alternate parallel writes
        step("R5 write ae", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, W'('h155));
        step("R5 write af", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, W'('h2AA));
        step("R5 write ae again", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, W'('h001));
        // R7: serial attempts in parallel mode
        for (int i = 0; i < 4; i++) step("R7 shift blocked", 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, '0);
        // R8: simultaneous read and write
        step("R8 rd+wr one advance", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, W'('h3C3));
        step("R8 read back", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0);
        // R9: load high
        step("R9 load high", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, W'('h0F0));
        step("R8 after idle", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0);

        // R2: serial strap defaults
        do_reset(1'b1);
        #1; check_all("R2 reset");
        // R3: full serial load
        pat = 20'hA5C3E;
        for (int i = 0; i < 2*W; i++) step("R3 shift", 1'b0, 1'b0, pat[i], 1'b1, 1'b1, '0);
        cmp("R3 ae from first bits", ae_offset, pat[W-1:0]);
        cmp("R3 af from last bits", af_offset, pat[2*W-1:W]);
        // R4 / R6
        step("R4 enable high", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0);
        step("R6 par write blocked", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, W'('h111));
        step("R8 serial read ae", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0);
        step("R8 serial read af", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0);
        step("R9 load high", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0);

        // random phases, both modes
        for (int m = 0; m < 2; m++) begin
            do_reset(m[0]);
            #1; check_all(m[0] ? "R2 rand reset" : "R1 rand reset");
            for (int i = 0; i < 400; i++)
                step(m[0] ? "R3_R4_R6_R8 rand" : "R5_R7_R8_R9 rand",
                     ($urandom % 4) == 0, $urandom % 2, $urandom % 2,
                     $urandom % 2, ($urandom % 3) != 0, W'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule